// File: doc/BRIEF.md
# I2C Bit Timing Engine

This block sits beneath a byte or transaction sequencer and turns single bit-level requests into waveforms on an open-drain I2C bus. The sequencer asks for a START, a STOP, one data bit to send, or one bit to receive. The engine then moves SCL and SDA through a fixed series of timed phases and answers with a one-cycle completion pulse that carries the sampled SDA level. Each timing figure is a separate input counted in system clock cycles: the full SCL period, the SCL low time, the setup and hold time for START and STOP, and the data setup time before SCL rises. A START asked for while the engine still holds SCL low after a bit becomes a repeated START by itself. Between bits SCL stays low, and the engine waits for the next request.

The pads use open-drain signalling. An output-enable of 1 pulls a line low, and a 0 releases it. The engine never drives a line high. While the engine has released SCL but SCL still reads low, a slave is stretching the clock, so the high-time count pauses and the phase is extended. A bus monitor reports the driven level and the read-back level of both lines. It also tracks bus ownership from START and STOP conditions seen on the wires. A two-bit mode control takes the engine out of normal operation, and SCL then follows software directly for bus recovery.

Top module: `i2c_bit_engine`

States: `ST_WAIT` (between requests), `ST_STA_HOLD` (SDA low with SCL released), `ST_RS_LOW` and `ST_RS_HIGH` (lead-in to a repeated START), `ST_B_HOLD`, `ST_B_SETUP` and `ST_B_HIGH` (one data bit), `ST_P_LOW`, `ST_P_HIGH` and `ST_P_REL` (STOP), and `ST_MANUAL` (software-driven SCL). Transitions:
- `ST_WAIT` takes START to `ST_STA_HOLD`, or to `ST_RS_LOW` if SCL is held. It takes STOP to `ST_P_LOW`, and a bit request to `ST_B_HOLD`.
- Repeated START runs `ST_RS_LOW` → `ST_RS_HIGH` → `ST_STA_HOLD` → `ST_WAIT`.
- A data bit runs `ST_B_HOLD` → `ST_B_SETUP` → `ST_B_HIGH` → `ST_WAIT`.
- STOP runs `ST_P_LOW` → `ST_P_HIGH` → `ST_P_REL` → `ST_WAIT`.
- Any state goes to `ST_MANUAL` when the mode control is not `2'b11`. `ST_MANUAL` goes back to `ST_WAIT` once it is.

A phase programmed to N clocks lasts N cycles, and a value of 0 counts as 1. Every phase with SCL released also waits for SCL to read high.

## Requirements
- R1: Request op codes on `req_op`: 0 = START, 1 = STOP, 2 = WRITE (send `req_bit`), 3 = READ (release SDA). A START on a free bus pulls SDA low with SCL released for `cfg_setup` clocks, then pulls SCL low and pulses `done`.
- R2: A START while SCL is held low gives a repeated START. SCL stays low with SDA released for `cfg_low` clocks, then SCL is released for `cfg_setup` clocks, then the START hold of R1 follows.
- R3: A data bit holds SCL low for `cfg_low` clocks. SDA takes the new level during the last `cfg_dsu` of those clocks. SCL is then released for `cfg_period - cfg_low` clocks.
- R4: A READ releases SDA. The `rx_bit` output returns SDA as sampled in the last released cycle of SCL. A WRITE returns the sampled level the same way.
- R5: A WRITE of 1 that samples SDA low sets `arb_lost` together with `done`. `arb_lost` is never high without `done`.
- R6: A STOP holds SCL and SDA low for `cfg_low` clocks and releases SCL for `cfg_setup` clocks. It then releases SDA and waits a further `cfg_setup` clocks before `done`, which leaves both lines released.
- R7: While the engine releases SCL and SCL reads low, the high-time count pauses and SCL stays released. A stretch of S clocks lengthens the released phase by S.
- R8: `bus_busy` rises after SDA falls with SCL high, and clears after SDA rises with SCL high. At that second event `stop_seen` sets, and it stays set until the next START.
- R9: `mon` bit 3 is the SDA output level, bit 2 the SDA input, bit 1 the SCL output level and bit 0 the SCL input. An output level is 1 when the line is released.
- R10: When `bus_ctl` is not `2'b11`, SDA is released, SCL is released if `bus_ctl[0]` is 1 and pulled low if it is 0, and requests are ignored. Setting `bus_ctl` to `2'b11` returns the engine to normal operation with the bus treated as free.
- R11: `req_ready` is high only while waiting in normal mode. `done` is a single-cycle pulse.
- R12: After reset both lines are released, `bus_busy`, `stop_seen` and `done` are low, and `req_ready` is high in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bit request valid |
| req_op | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| req_bit | input | 1 | Bit value for WRITE |
| req_ready | output | 1 | Engine can accept a request |
| done | output | 1 | Request finished (one cycle) |
| rx_bit | output | 1 | SDA sampled during the bit's high phase |
| arb_lost | output | 1 | Sent 1 but read 0 |
| cfg_period | input | CNT_W | Full SCL period in clocks |
| cfg_low | input | CNT_W | SCL low time in clocks |
| cfg_setup | input | CNT_W | START/STOP setup and hold in clocks |
| cfg_dsu | input | CNT_W | Data setup before SCL rise in clocks |
| bus_ctl | input | 2 | Bit 1 normal operation, bit 0 SCL release |
| mon | output | 4 | {SDA out, SDA in, SCL out, SCL in} |
| bus_busy | output | 1 | Bus owned between START and STOP |
| stop_seen | output | 1 | STOP observed since the last START |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | SCL pad level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA pad level |

## Verification
The bench builds the engine with an 8-bit counter width and sets period 20, low 11, setup 10 and data setup 3. These values keep every phase a few clocks long and distinct from the others, so the counted SCL low and high lengths identify which phase went wrong. Data setup is smaller than the low time, so the hold and setup portions of a bit can be told apart by where SDA changes. A five-clock stretch and a slave pull on SDA during a sent 1 bring clock stretching and the mismatch flag into reach.

// File: rtl/i2c_be_pkg.sv
package i2c_be_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } be_op_e;

    typedef enum logic [3:0] {
        ST_WAIT,
        ST_STA_HOLD,
        ST_RS_LOW,
        ST_RS_HIGH,
        ST_B_HOLD,
        ST_B_SETUP,
        ST_B_HIGH,
        ST_P_LOW,
        ST_P_HIGH,
        ST_P_REL,
        ST_MANUAL
    } be_state_e;

endpackage

// File: rtl/i2c_be_timer.sv
module i2c_be_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (en && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_be_busmon.sv
module i2c_be_busmon (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_oe,
    input  logic       sda_oe,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic [3:0] mon,
    output logic       bus_busy,
    output logic       stop_seen
);
    logic scl_q, sda_q;
    logic start_ev, stop_ev;

    assign start_ev = scl_q && scl_in && sda_q && !sda_in;
    assign stop_ev  = scl_q && scl_in && !sda_q && sda_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            bus_busy  <= 1'b0;
            stop_seen <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (start_ev) begin
                bus_busy  <= 1'b1;
                stop_seen <= 1'b0;
            end else if (stop_ev) begin
                bus_busy  <= 1'b0;
                stop_seen <= 1'b1;
            end
        end
    end

    assign mon = {!sda_oe, sda_in, !scl_oe, scl_in};
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_be_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_bit,
    output logic             req_ready,
    output logic             done,
    output logic             rx_bit,
    output logic             arb_lost,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_dsu,
    input  logic [1:0]       bus_ctl,
    output logic [3:0]       mon,
    output logic             bus_busy,
    output logic             stop_seen,
    output logic             scl_oe,
    input  logic             scl_in,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    function automatic logic [CNT_W-1:0] phase_len(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - ONE;
    endfunction

    be_state_e        st, st_n;
    logic             normal;
    logic             scl_held, sda_low_q;
    logic             op_low, op_wr;
    logic             done_q, rx_q, arb_q;
    logic             ld, t_zero, t_en, scl_rel, go;
    logic [CNT_W-1:0] ld_val, hold_raw, high_raw;

    assign normal   = (bus_ctl == 2'b11);
    assign hold_raw = (cfg_low > cfg_dsu) ? cfg_low - cfg_dsu : ONE;
    assign high_raw = (cfg_period > cfg_low) ? cfg_period - cfg_low : ONE;
    assign scl_rel  = !scl_oe;
    assign t_en     = !scl_rel || scl_in;
    assign go       = t_zero && t_en;

    i2c_be_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .en       (t_en),
        .zero     (t_zero)
    );

    i2c_be_busmon u_busmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .mon       (mon),
        .bus_busy  (bus_busy),
        .stop_seen (stop_seen)
    );

    // next state and phase length
    always_comb begin
        st_n   = st;
        ld     = 1'b0;
        ld_val = '0;
        if (!normal) begin
            st_n = ST_MANUAL;
        end else begin
            unique case (st)
                ST_MANUAL: st_n = ST_WAIT;
                ST_WAIT: begin
                    if (req_valid) begin
                        ld = 1'b1;
                        unique case (be_op_e'(req_op))
                            OP_START: begin
                                st_n   = scl_held ? ST_RS_LOW : ST_STA_HOLD;
                                ld_val = scl_held ? phase_len(cfg_low) : phase_len(cfg_setup);
                            end
                            OP_STOP: begin
                                st_n   = ST_P_LOW;
                                ld_val = phase_len(cfg_low);
                            end
                            OP_WRITE, OP_READ: begin
                                st_n   = ST_B_HOLD;
                                ld_val = phase_len(hold_raw);
                            end
                        endcase
                    end
                end
                ST_STA_HOLD: if (go) st_n = ST_WAIT;
                ST_RS_LOW: if (go) begin
                    st_n = ST_RS_HIGH; ld = 1'b1; ld_val = phase_len(cfg_setup);
                end
                ST_RS_HIGH: if (go) begin
                    st_n = ST_STA_HOLD; ld = 1'b1; ld_val = phase_len(cfg_setup);
                end
                ST_B_HOLD: if (go) begin
                    st_n = ST_B_SETUP; ld = 1'b1; ld_val = phase_len(cfg_dsu);
                end
                ST_B_SETUP: if (go) begin
                    st_n = ST_B_HIGH; ld = 1'b1; ld_val = phase_len(high_raw);
                end
                ST_B_HIGH: if (go) st_n = ST_WAIT;
                ST_P_LOW: if (go) begin
                    st_n = ST_P_HIGH; ld = 1'b1; ld_val = phase_len(cfg_setup);
                end
                ST_P_HIGH: if (go) begin
                    st_n = ST_P_REL; ld = 1'b1; ld_val = phase_len(cfg_setup);
                end
                ST_P_REL: if (go) st_n = ST_WAIT;
                default: st_n = ST_WAIT;
            endcase
        end
    end

    // state register and per-request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_WAIT;
            scl_held  <= 1'b0;
            sda_low_q <= 1'b0;
            op_low    <= 1'b0;
            op_wr     <= 1'b0;
            done_q    <= 1'b0;
            rx_q      <= 1'b1;
            arb_q     <= 1'b0;
        end else begin
            st     <= st_n;
            done_q <= 1'b0;
            arb_q  <= 1'b0;
            if (st == ST_WAIT && normal && req_valid) begin
                op_wr  <= (be_op_e'(req_op) == OP_WRITE);
                op_low <= (be_op_e'(req_op) == OP_WRITE) && !req_bit;
            end
            if (st_n == ST_MANUAL) begin
                scl_held  <= 1'b0;
                sda_low_q <= 1'b0;
            end else if (st_n == ST_WAIT && st != ST_WAIT && st != ST_MANUAL) begin
                done_q <= 1'b1;
                if (st == ST_STA_HOLD) begin
                    scl_held  <= 1'b1;
                    sda_low_q <= 1'b1;
                end else if (st == ST_B_HIGH) begin
                    scl_held  <= 1'b1;
                    sda_low_q <= op_low;
                    rx_q      <= sda_in;
                    arb_q     <= op_wr && !op_low && !sda_in;
                end else begin
                    scl_held  <= 1'b0;
                    sda_low_q <= 1'b0;
                end
            end
        end
    end

    // pad outputs per state (1 = pull low)
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (st)
            ST_WAIT:     begin scl_oe = scl_held; sda_oe = sda_low_q; end
            ST_STA_HOLD: begin scl_oe = 1'b0;     sda_oe = 1'b1;      end
            ST_RS_LOW:   begin scl_oe = 1'b1;     sda_oe = 1'b0;      end
            ST_RS_HIGH:  begin scl_oe = 1'b0;     sda_oe = 1'b0;      end
            ST_B_HOLD:   begin scl_oe = 1'b1;     sda_oe = sda_low_q; end
            ST_B_SETUP:  begin scl_oe = 1'b1;     sda_oe = op_low;    end
            ST_B_HIGH:   begin scl_oe = 1'b0;     sda_oe = op_low;    end
            ST_P_LOW:    begin scl_oe = 1'b1;     sda_oe = 1'b1;      end
            ST_P_HIGH:   begin scl_oe = 1'b0;     sda_oe = 1'b1;      end
            ST_P_REL:    begin scl_oe = 1'b0;     sda_oe = 1'b0;      end
            ST_MANUAL:   begin scl_oe = !bus_ctl[0]; sda_oe = 1'b0;   end
            default:     begin scl_oe = 1'b0;     sda_oe = 1'b0;      end
        endcase
    end

    assign req_ready = (st == ST_WAIT) && normal;
    assign done      = done_q;
    assign rx_bit    = rx_q;
    assign arb_lost  = arb_q;
endmodule

// File: rtl/i2c_be_chk.sv
module i2c_be_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic       arb_lost,
    input logic [1:0] bus_ctl,
    input logic       bus_busy,
    input logic       stop_seen,
    input logic       scl_oe,
    input logic       scl_in
);
    AST_MANUAL_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_ctl) != 2'b11 && bus_ctl != 2'b11) |-> (scl_oe == !bus_ctl[0])); // R10

    AST_NO_READY_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ctl != 2'b11) |=> !req_ready); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_ARB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> done); // R5

    AST_STOP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> !bus_busy); // R8

    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ctl == 2'b11 && !scl_oe && !scl_in && !req_ready) |=> !scl_oe); // R7
endmodule

bind i2c_bit_engine i2c_be_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .arb_lost  (arb_lost),
    .bus_ctl   (bus_ctl),
    .bus_busy  (bus_busy),
    .stop_seen (stop_seen),
    .scl_oe    (scl_oe),
    .scl_in    (scl_in)
);

// File: tb/i2c_bit_engine_tb.sv
module i2c_bit_engine_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic req_bit = 1'b0;
    logic req_ready, done, rx_bit, arb_lost;
    logic [W-1:0] cfg_period = W'(20);
    logic [W-1:0] cfg_low = W'(11);
    logic [W-1:0] cfg_setup = W'(10);
    logic [W-1:0] cfg_dsu = W'(3);
    logic [1:0] bus_ctl = 2'b11;
    logic [3:0] mon;
    logic bus_busy, stop_seen, scl_oe, sda_oe, scl_in, sda_in;
    logic pull = 1'b0, stretch = 1'b0, ext_low = 1'b0;
    int stretch_left = 0;
    int checks = 0, failures = 0;
    int lo, hi, su;

    assign scl_in = !scl_oe && !stretch && !ext_low;
    assign sda_in = !sda_oe && !pull;

    always #5 clk = !clk;

    i2c_bit_engine #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bit(req_bit), .req_ready(req_ready), .done(done), .rx_bit(rx_bit),
        .arb_lost(arb_lost), .cfg_period(cfg_period), .cfg_low(cfg_low),
        .cfg_setup(cfg_setup), .cfg_dsu(cfg_dsu), .bus_ctl(bus_ctl), .mon(mon),
        .bus_busy(bus_busy), .stop_seen(stop_seen), .scl_oe(scl_oe),
        .scl_in(scl_in), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    always @(negedge clk) begin
        if (stretch_left > 0 && !scl_oe) begin
            stretch <= 1'b1;
            stretch_left <= stretch_left - 1;
        end else begin
            stretch <= 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // issue one request and measure SCL low/high cycles and SDA setup
    task automatic do_op(input logic [1:0] op, input logic b);
        logic prev;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_bit = b;
        prev = sda_oe;
        lo = 0; hi = 0; su = 0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 500; i++) begin
            if (done) break;
            if (scl_oe) begin
                lo++;
                if (sda_oe != prev) su = 1; else su++;
                prev = sda_oe;
            end else begin
                hi++;
            end
            @(negedge clk);
        end
    endtask

    // {op[25:24], bit, pull, rx, arb, lo[19:12], hi[11:4], su[3:0]}
    localparam logic [25:0] VEC [0:9] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd10, 4'd0},
        {2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'd11, 8'd9,  4'd3},
        {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11, 8'd9,  4'd3},
        {2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 8'd11, 8'd9,  4'd3},
        {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'd11, 8'd9,  4'd0},
        {2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'd11, 8'd9,  4'd0},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11, 8'd20, 4'd0},
        {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11, 8'd9,  4'd0},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11, 8'd20, 4'd0},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd10, 4'd0}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 scl released", scl_oe, 0);
        chk("R12 sda released", sda_oe, 0);
        chk("R12 busy low", bus_busy, 0);
        chk("R12 stop_seen low", stop_seen, 0);
        chk("R12 done low", done, 0);
        chk("R12 ready", req_ready, 1);
        chk("R9 idle monitor", mon, 4'b1111);

        for (int v = 0; v < 10; v++) begin
            logic [25:0] e;
            e = VEC[v];
            pull = e[22];
            do_op(e[25:24], e[23]);
            chk($sformatf("R1 R2 R3 R6 scl low v%0d", v), lo, int'(e[19:12]));
            chk($sformatf("R1 R2 R3 R6 scl high v%0d", v), hi, int'(e[11:4]));
            if (e[3:0] != 0) chk($sformatf("R3 data setup v%0d", v), su, int'(e[3:0]));
            if (e[25]) chk($sformatf("R4 rx v%0d", v), rx_bit, int'(e[21]));
            chk($sformatf("R5 arb v%0d", v), arb_lost, int'(e[20]));
            chk($sformatf("R8 busy v%0d", v), bus_busy, (e[25:24] != 2'd1) ? 1 : 0);
            chk($sformatf("R8 stop_seen v%0d", v), stop_seen, (e[25:24] == 2'd1) ? 1 : 0);
            @(negedge clk);
            pull = 1'b0;
            chk($sformatf("R11 done single v%0d", v), done, 0);
        end
        chk("R9 monitor after START", mon, 4'b0000);

        // R7: five-cycle stretch on a data bit
        stretch_left = 5;
        do_op(2'd2, 1'b1);
        chk("R7 stretched high", hi, 14);
        chk("R7 low unaffected", lo, 11);

        do_op(2'd1, 1'b0);
        chk("R6 stop leaves lines released", {scl_oe, sda_oe}, 0);
        chk("R8 stop flag", stop_seen, 1);

        // R10: manual mode
        @(negedge clk);
        bus_ctl = 2'b00;
        req_valid = 1'b1; req_op = 2'd0;
        @(negedge clk);
        chk("R10 manual pulls scl", scl_oe, 1);
        chk("R9 R10 manual monitor", mon, 4'b1100);
        chk("R11 not ready manual", req_ready, 0);
        bus_ctl = 2'b01;
        @(negedge clk);
        chk("R10 manual release scl", mon, 4'b1111);
        ext_low = 1'b1;
        @(negedge clk);
        chk("R9 scl readback", mon, 4'b1110);
        chk("R10 request ignored", done, 0);
        ext_low = 1'b0;
        req_valid = 1'b0;
        bus_ctl = 2'b11;
        @(negedge clk);
        chk("R10 back to normal", req_ready, 1);
        chk("R10 lines free", {scl_oe, sda_oe}, 0);
        do_op(2'd0, 1'b0);
        chk("R10 fresh START after manual", hi, 10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule